// File: doc/BRIEF.md
# Time-Sliced Event Word Transmitter

The block moves detector event words from an internal requester onto sixteen serial data lanes, arranged as four groups of four lanes. Time is cut into fixed slices by a periodic boundary pulse that marks the first clock of every slice. Each lane group carries at most one word per slice. A slice lasts 8 clocks with 32-bit words, or 16 clocks with 64-bit words. The slice length is chosen by a mode input, which is sampled on each boundary. A word never starts in one slice and ends in the next.

Every lane sends one bit per clock. Each group has a word-present flag that stays high for exactly the cycles that carry the word. The block also sends a forwarded copy of the clock and a delayed boundary marker. The marker lines up with the first bit, so a receiver can rebuild the words. Each group has a one-deep holding register that uses a valid/ready handshake. A word accepted on the boundary cycle itself goes out in that slice. A word accepted on any later cycle waits for the next boundary.

Top module: `slice_word_tx`

## Requirements
- R1: After reset all flags are low, all lanes are zero, every `req_ready` is high and `tx_bnd` is low.
- R2: `tx_clk` follows `clk`. `tx_bnd` is high for one cycle, exactly one clock after `slice_start` is sampled high, together with the first bit of the slice.
- R3: When the slice is short (`long_mode` low at the boundary), a group's word is bits [31:0] of its request. On beat t (0..7, beat 0 in the `tx_bnd` cycle), lane k of that group carries word bit 4*(7-t)+k.
- R4: When the slice is long (`long_mode` high at the boundary), a group's 64-bit word is sent over 16 beats. On beat t, lane k carries word bit 4*(15-t)+k.
- R5: A group's flag is high on exactly the beats of a slice in which that group sends a word. Whenever the flag is low, the group's lanes are zero.
- R6: A request that is accepted on the boundary cycle, while the holding register is empty, is sent in the slice that begins at that boundary. Its holding register stays empty.
- R7: A request that is accepted after the boundary cycle is held, and it is sent in the next slice. `req_ready` for that group is low while the word is held.
- R8: The slice length in use changes only at a boundary. Toggling `long_mode` inside a slice does not alter the word being sent.
- R9: Group g uses `tx_data[4g+3:4g]` and `tx_flag[g]` only. Groups load and send independently.
- R10: If the next boundary comes late, a group's flag drops after the last beat of its word. The lanes then stay zero until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_mode | input | 1 | 1 selects 16-beat slices with 64-bit words, 0 selects 8-beat slices with 32-bit words; sampled at each boundary |
| slice_start | input | 1 | System boundary pulse, high on the first clock of each slice |
| req_valid | input | 4 | Per-group word request |
| req_word | input | 256 | Per-group word, group g in bits [64g+63:64g] |
| req_ready | output | 4 | Per-group ready; high while the holding register is empty |
| tx_clk | output | 1 | Forwarded clock |
| tx_bnd | output | 1 | Forwarded boundary marker, aligned with beat 0 |
| tx_data | output | 16 | Serial data lanes, four per group |
| tx_flag | output | 4 | Per-group word-present flag |

## Verification
The bench targets the boundary cycle itself. If a design parked a word presented exactly on the boundary in the holding register, that word would go out one slice late and its flag would be missing where it is expected. A design that ignored the holding register would lose the second of two back-to-back words. A design that read `long_mode` live would stop short or overrun when the mode flips mid-slice. Late boundaries are also exercised: a counter that wrapped without saturating would raise the flag again or leave stale bits on the lanes between words.

// File: rtl/slice_tx_pkg.sv
package slice_tx_pkg;
   typedef enum logic {
      SLICE_SHORT = 1'b0,
      SLICE_LONG  = 1'b1
   } slice_mode_e;
endpackage

// File: rtl/slice_tx_timer.sv
module slice_tx_timer
   import slice_tx_pkg::*;
#(
   parameter int SHORT_BEATS = 8,
   parameter int LONG_BEATS  = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slice_start,
   input  logic        long_mode,
   output slice_mode_e mode_q,
   output logic        last_beat,
   output logic        bnd_q
);
   localparam int BW = $clog2(LONG_BEATS);

   logic [BW-1:0] beat;
   logic [BW-1:0] last_idx;

   assign last_idx  = (mode_q == SLICE_LONG) ? BW'(LONG_BEATS - 1) : BW'(SHORT_BEATS - 1);
   assign last_beat = (beat >= last_idx);

   // beat saturates at the last index so an overdue boundary leaves the slice idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat   <= '1;
         mode_q <= SLICE_SHORT;
         bnd_q  <= 1'b0;
      end else begin
         bnd_q <= slice_start;
         if (slice_start) begin
            beat   <= '0;
            mode_q <= long_mode ? SLICE_LONG : SLICE_SHORT;
         end else if (beat < last_idx) begin
            beat <= beat + 1'b1;
         end
      end
   end

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_start |=> $stable(mode_q)); // R8
   AST_BEAT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat && !slice_start |=> last_beat); // R10
endmodule

// File: rtl/slice_tx_group.sv
module slice_tx_group #(
   parameter int LANES       = 4,
   parameter int SHORT_BEATS = 8,
   parameter int LONG_BEATS  = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           slice_start,
   input  logic                           long_mode,
   input  logic                           last_beat,
   input  logic                           req_valid,
   input  logic [LANES*LONG_BEATS-1:0]    req_word,
   output logic                           req_ready,
   output logic [LANES-1:0]               lane_data,
   output logic                           lane_flag
);
   localparam int WORD_W  = LANES * LONG_BEATS;
   localparam int SHORT_W = LANES * SHORT_BEATS;

   logic [WORD_W-1:0] hold_word;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] load_word;
   logic [WORD_W-1:0] pad_word;
   logic              hold_full;
   logic              take;
   logic              src_ok;

   assign req_ready = !hold_full;
   assign take      = req_valid && !hold_full;
   assign src_ok    = hold_full || take;
   assign load_word = hold_full ? hold_word : req_word;

   // short words ride in the top of the shifter so the lane nibble is always the MSBs
   generate
      if (SHORT_W < WORD_W) begin : g_pad
         assign pad_word = long_mode ? load_word
                                     : {load_word[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}};
      end else begin : g_nopad
         assign pad_word = load_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_word <= '0;
         hold_full <= 1'b0;
         shreg     <= '0;
         lane_flag <= 1'b0;
      end else if (slice_start) begin
         hold_full <= 1'b0;
         lane_flag <= src_ok;
         shreg     <= src_ok ? pad_word : '0;
      end else begin
         if (take) begin
            hold_word <= req_word;
            hold_full <= 1'b1;
         end
         shreg <= shreg << LANES;
         if (last_beat) lane_flag <= 1'b0;
      end
   end

   assign lane_data = shreg[WORD_W-1 -: LANES];

   AST_FLAG_FROM_BND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_flag) |-> $past(slice_start)); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_flag |-> (lane_data == '0)); // R5
   AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      hold_full && !slice_start |=> hold_full && $stable(hold_word)); // R7
   AST_WORD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      lane_flag && last_beat && !slice_start |=> !lane_flag); // R10
endmodule

// File: rtl/slice_word_tx.sv
module slice_word_tx #(
   parameter int GROUPS      = 4,
   parameter int LANES       = 4,
   parameter int SHORT_BEATS = 8,
   parameter int LONG_BEATS  = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                long_mode,
   input  logic                                slice_start,
   input  logic [GROUPS-1:0]                   req_valid,
   input  logic [GROUPS*LANES*LONG_BEATS-1:0]  req_word,
   output logic [GROUPS-1:0]                   req_ready,
   output logic                                tx_clk,
   output logic                                tx_bnd,
   output logic [GROUPS*LANES-1:0]             tx_data,
   output logic [GROUPS-1:0]                   tx_flag
);
   import slice_tx_pkg::*;

   localparam int WORD_W = LANES * LONG_BEATS;

   generate
      if (GROUPS < 1 || LANES < 1) begin : g_bad_shape
         $error("slice_word_tx: GROUPS and LANES must be at least 1");
      end
      if (SHORT_BEATS < 2 || SHORT_BEATS >= LONG_BEATS) begin : g_bad_beats
         $error("slice_word_tx: need 2 <= SHORT_BEATS < LONG_BEATS");
      end
   endgenerate

   slice_mode_e mode_q;
   logic        last_beat;

   slice_tx_timer #(
      .SHORT_BEATS (SHORT_BEATS),
      .LONG_BEATS  (LONG_BEATS)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .slice_start (slice_start),
      .long_mode   (long_mode),
      .mode_q      (mode_q),
      .last_beat   (last_beat),
      .bnd_q       (tx_bnd)
   );

   assign tx_clk = clk;

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         slice_tx_group #(
            .LANES       (LANES),
            .SHORT_BEATS (SHORT_BEATS),
            .LONG_BEATS  (LONG_BEATS)
         ) u_grp (
            .clk         (clk),
            .rst_n       (rst_n),
            .slice_start (slice_start),
            .long_mode   (long_mode),
            .last_beat   (last_beat),
            .req_valid   (req_valid[g]),
            .req_word    (req_word[g*WORD_W +: WORD_W]),
            .req_ready   (req_ready[g]),
            .lane_data   (tx_data[g*LANES +: LANES]),
            .lane_flag   (tx_flag[g])
         );
      end
   endgenerate

   AST_BND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bnd && !$past(slice_start) |-> 1'b0); // R2
   AST_FLAGS_ONEHOT_OR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bnd |-> (mode_q == (long_mode ? SLICE_LONG : SLICE_SHORT)) || !$stable(long_mode)); // R8
endmodule

// File: tb/slice_word_tx_bench.sv
module slice_word_tx_bench;
   localparam int G  = 4;
   localparam int L  = 4;
   localparam int SB = 8;
   localparam int LB = 16;
   localparam int W  = L * LB;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             long_mode = 1'b0;
   logic             slice_start = 1'b0;
   logic [G-1:0]     vld = '0;
   logic [W-1:0]     wrd [G];
   logic [G*W-1:0]   req_word;
   logic [G-1:0]     req_ready;
   logic             tx_clk;
   logic             tx_bnd;
   logic [G*L-1:0]   tx_data;
   logic [G-1:0]     tx_flag;

   for (genvar g = 0; g < G; g++) begin : g_pack
      assign req_word[g*W +: W] = wrd[g];
   end

   slice_word_tx u_slice_word_tx (
      .clk (clk), .rst_n (rst_n), .long_mode (long_mode), .slice_start (slice_start),
      .req_valid (vld), .req_word (req_word), .req_ready (req_ready),
      .tx_clk (tx_clk), .tx_bnd (tx_bnd), .tx_data (tx_data), .tx_flag (tx_flag)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard: one queue of expected words per group
   logic [63:0] sb_q [G][$];

   bit          run = 1'b0;
   int          gen_cnt = 0;
   int          gen_per = SB;
   int          gap = 0;
   bit          pend_long = 1'b0;
   bit          cap_long = 1'b0;
   bit          cap_on = 1'b0;
   int          cap_n = SB;
   int          cap_i = 0;
   bit          eflag [G];
   logic [63:0] eword [G];
   logic [63:0] acc [G];

   // monitor first, then the boundary generator, in one process
   always @(negedge clk) begin
      if (run) begin
         chk(tx_bnd == slice_start, "R2 boundary marker", 64'(tx_bnd), 64'(slice_start));
         if (tx_bnd) begin
            cap_on   = 1'b1;
            cap_i    = 0;
            cap_long = pend_long;
            cap_n    = cap_long ? LB : SB;
            for (int g = 0; g < G; g++) begin
               eflag[g] = (sb_q[g].size() != 0);
               eword[g] = '0;
               if (eflag[g]) eword[g] = sb_q[g].pop_front();
               if (!cap_long) eword[g] = eword[g] & 64'hFFFF_FFFF;
               acc[g] = '0;
            end
         end
         if (cap_on) begin
            for (int g = 0; g < G; g++) begin
               chk(tx_flag[g] == eflag[g], "R5/R6/R7 word flag", 64'(tx_flag[g]), 64'(eflag[g]));
               acc[g] = {acc[g][59:0], tx_data[g*L +: L]};
            end
            cap_i++;
            if (cap_i == cap_n) begin
               cap_on = 1'b0;
               for (int g = 0; g < G; g++)
                  chk(acc[g] == eword[g], cap_long ? "R4/R8/R9 long word" : "R3/R9 short word",
                      acc[g], eword[g]);
            end
         end else begin
            for (int g = 0; g < G; g++)
               chk(tx_flag[g] == 1'b0 && tx_data[g*L +: L] == '0, "R10 idle lanes",
                   64'({tx_flag[g], tx_data[g*L +: L]}), 64'd0);
         end
         if (gen_cnt == 0) begin
            slice_start = 1'b1;
            pend_long   = long_mode;
            gen_per     = (long_mode ? LB : SB) + gap;
         end else begin
            slice_start = 1'b0;
         end
         gen_cnt = (gen_cnt + 1) % gen_per;
      end
   end

   // called just after a rising edge; returns just after the accepting edge
   task automatic send(int g, logic [63:0] w);
      logic r;
      wrd[g] = w;
      vld[g] = 1'b1;
      forever begin
         r = req_ready[g];
         @(posedge clk);
         if (r) begin
            sb_q[g].push_back(w);
            break;
         end
         #1;
      end
      #1 vld[g] = 1'b0;
   endtask

   task automatic wait_cnt(int c);
      do begin
         @(posedge clk);
         #1;
      end while (gen_cnt != c);
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic run_all();
      for (int g = 0; g < G; g++) wrd[g] = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(tx_flag == '0, "R1 flags after reset", 64'(tx_flag), 64'd0);
      chk(tx_data == '0, "R1 lanes after reset", 64'(tx_data), 64'd0);
      chk(req_ready == '1, "R1 ready after reset", 64'(req_ready), 64'hF);
      chk(tx_bnd == 1'b0, "R1 marker after reset", 64'(tx_bnd), 64'd0);
      chk(tx_clk == 1'b0, "R2 forwarded clock low", 64'(tx_clk), 64'd0);
      @(posedge clk);
      #1;
      chk(tx_clk == 1'b1, "R2 forwarded clock high", 64'(tx_clk), 64'd1);
      run = 1'b1;
      idle(10);

      // short slices, every group at once
      wait_cnt(2);
      fork
         send(0, 64'hDEAD_BEEF_1234_5678);
         send(1, 64'h0000_0000_A5A5_5A5A);
         send(2, 64'h1111_1111_8000_0001);
         send(3, 64'hFFFF_FFFF_0F1E_2D3C);
      join
      idle(24);

      // R9: only two groups carry words
      wait_cnt(5);
      fork
         send(1, 64'h0000_0000_CAFE_F00D);
         send(3, 64'h0000_0000_7654_3210);
      join
      idle(24);

      // R7: second word stalls behind the held one
      wait_cnt(3);
      send(0, 64'h0000_0000_1357_9BDF);
      chk(req_ready[0] == 1'b0, "R7 ready low while held", 64'(req_ready[0]), 64'd0);
      send(0, 64'h0000_0000_2468_ACE0);
      idle(30);

      // R6: request on the boundary cycle goes straight out
      wait_cnt(0);
      send(2, 64'h0000_0000_B00B_1E55);
      chk(req_ready[2] == 1'b1, "R6 holding register bypassed", 64'(req_ready[2]), 64'd1);
      idle(24);

      // R4: long slices
      long_mode = 1'b1;
      idle(40);
      wait_cnt(4);
      fork
         send(0, 64'h0123_4567_89AB_CDEF);
         send(1, 64'hFEDC_BA98_7654_3210);
         send(2, 64'h8000_0000_0000_0001);
         send(3, 64'h5555_AAAA_3333_CCCC);
      join
      idle(50);

      // R8: mode flips inside the slice carrying the word
      wait_cnt(2);
      send(1, 64'hA1B2_C3D4_E5F6_0718);
      wait_cnt(3);
      long_mode = 1'b0;
      wait_cnt(6);
      long_mode = 1'b1;
      idle(50);

      // R10: late boundaries, long then short
      gap = 5;
      idle(40);
      wait_cnt(3);
      fork
         send(0, 64'h0F0F_F0F0_1234_4321);
         send(3, 64'h9999_0000_6666_1111);
      join
      idle(60);
      long_mode = 1'b0;
      gap = 3;
      idle(40);
      wait_cnt(3);
      fork
         send(1, 64'h0000_0000_89AB_0246);
         send(2, 64'h0000_0000_FEED_C0DE);
      join
      idle(40);
      gap = 0;
      idle(40);

      for (int g = 0; g < G; g++)
         chk(sb_q[g].size() == 0, "R7 every accepted word delivered", 64'(sb_q[g].size()), 64'd0);
   endtask

   initial begin
      fork
         run_all();
         begin
            #800000;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule